// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Slave

This block is a slave on a two-wire serial bus that sits in front of a 2048-byte synchronous memory array. It samples the clock and data lines, finds start and stop conditions, and decodes a slave byte. The slave byte carries a fixed 4-bit device code, three page bits and a direction flag. Data is modelled as an open-drain line: the block only ever pulls it low, through a drive-low enable, and the pull-up and any other drivers sit outside.

Memory is addressed through an 11-bit address latch. A write transfer carries one word-address byte. That byte supplies the low eight bits of the latch, and the page bits of the slave byte supply the high three. The data bytes that follow are stored at once, one per byte, with no buffering. A read transfer has no word-address byte. It takes the page bits from its slave byte and keeps the low eight bits already in the latch, so it continues from the last access. Every byte transferred moves the latch forward by one, wrapping at the top of the array. A write-protect input makes every write data byte go unacknowledged and leaves both the array and the latch untouched.

Top module: `twi_mem_slave`

## Requirements
- R1: After reset, and after any stop condition, the block does not pull the data line low.
- R2: A slave byte whose top four bits (bits 7..4, first on the wire) equal 4'b1010 is acknowledged. Any other code gets no acknowledge, and the block then ignores the bus until the next start condition, including any later bytes and the address latch.
- R3: In a write (slave byte bit 0 = 0), the next byte is the word address. The latch becomes {page bits 3..1 of the slave byte, word address}. Each later data byte, sent MSB first, is acknowledged and stored at the latch address.
- R4: In a read (slave byte bit 0 = 1) there is no address byte. The latch keeps its low eight bits and takes its high three bits from the slave byte. The block sends the byte at that address MSB first, pulling the line low for each 0 bit.
- R5: After the eighth bit of each data byte, read or written, the latch increments before the acknowledge slot. It wraps from 0x7FF to 0x000, and a later transfer continues from the incremented value.
- R6: In a read, a master acknowledge (line low) makes the block send the next sequential byte. A master no-acknowledge ends the read, and the line is left released.
- R7: While the write-protect input is high, every write data byte gets no acknowledge, the array is not written and the latch does not increment.
- R8: A start or stop condition seen before the eighth bit of a write data byte abandons that byte and leaves the array unchanged.
- R9: A start condition seen at any point, including a repeated start inside a write, returns the block to receiving a slave byte.
- R10: The block changes its drive only while the synchronized clock line is low. Each acknowledge pulls the line low for exactly one clock-high period, and the block never drives while the master is sending bits.
- R11: A slave byte sent right after a write is always acknowledged; there is no busy state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus (wired-AND of all drivers) |
| wp | input | 1 | Write protect; high blocks all array writes |
| sda_drive_low | output | 1 | Registered open-drain enable: 1 pulls the data line low |

## Verification
Each bus line passes two synchronizer flops, and the drive register adds one more. The drive output therefore settles three system clocks after the clock line falls, and an array write or latch step lands three clocks after the rising edge of the eighth bit. The bench holds each clock half-period for eight system clocks. It holds an expected drive value for every bit slot and compares it with the output on every falling system-clock edge while the bus clock is high, where the output of a correct design is settled. The expected data, acknowledges and latch address come from a behavioural byte-array model that is updated as each byte is sent.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WORD,
    ST_WORD_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK
  } twi_state_e;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int LANES = 2;

  logic [LANES-1:0] raw;
  logic [LANES-1:0] synced;
  logic [LANES-1:0] prev;

  assign raw = {sda_in, scl_in};

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      logic [STAGES-1:0] pipe;
      always_ff @(posedge clk) begin
        if (rst) begin
          pipe    <= '1;
          prev[g] <= 1'b1;
        end else begin
          pipe    <= {pipe[STAGES-2:0], raw[g]};
          prev[g] <= pipe[STAGES-1];
        end
      end
      assign synced[g] = pipe[STAGES-1];
    end
  endgenerate

  assign scl_s     = synced[0];
  assign sda_s     = synced[1];
  assign scl_rise  = synced[0] & ~prev[0];
  assign scl_fall  = ~synced[0] & prev[0];
  assign start_det = synced[0] & prev[0] & prev[1] & ~synced[1];
  assign stop_det  = synced[0] & prev[0] & ~prev[1] & synced[1];

endmodule

// File: rtl/twi_byte_ram.sv
module twi_byte_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/twi_slave_fsm.sv
module twi_slave_fsm
  import twi_mem_pkg::*;
#(
  parameter int          ADDR_W   = 11,
  parameter int          PAGE_W   = 3,
  parameter logic [3:0]  DEV_CODE = 4'b1010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wp,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              mem_we,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic [ADDR_W-1:0] addr,
  output logic              sda_drive_low
);

  localparam int WORD_W = ADDR_W - PAGE_W;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  twi_state_e        st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-2:0] sh;
  logic [BYTE_W-1:0] tx;
  logic              ack_q;
  logic              mack_q;
  logic [ADDR_W-1:0] addr_q;
  logic              drv_q;

  logic [BYTE_W-1:0] rx_byte;
  logic              last_bit;
  logic              byte_done;
  logic              bus_evt;

  assign rx_byte   = {sh, sda_s};
  assign last_bit  = (cnt == LAST);
  assign byte_done = (cnt == FULL);
  assign bus_evt   = start_det | stop_det;

  always_comb begin
    mem_we = 1'b0;
    if (!bus_evt && scl_rise && st == ST_WDATA && last_bit && !wp) mem_we = 1'b1;
  end

  assign mem_wdata     = rx_byte;
  assign addr          = addr_q;
  assign sda_drive_low = drv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      sh     <= '0;
      tx     <= '0;
      ack_q  <= 1'b0;
      mack_q <= 1'b1;
      addr_q <= '0;
      drv_q  <= 1'b0;
    end else if (start_det) begin
      st    <= ST_DEV;
      cnt   <= '0;
      drv_q <= 1'b0;
    end else if (stop_det) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      drv_q <= 1'b0;
    end else if (scl_rise) begin
      case (st)
        ST_DEV, ST_WORD, ST_WDATA: begin
          if (!byte_done) begin
            sh  <= rx_byte[BYTE_W-2:0];
            cnt <= cnt + 1'b1;
            if (last_bit) begin
              if (st == ST_DEV) begin
                ack_q <= (rx_byte[BYTE_W-1:BYTE_W-4] == DEV_CODE);
                if (rx_byte[BYTE_W-1:BYTE_W-4] == DEV_CODE)
                  addr_q[ADDR_W-1:WORD_W] <= rx_byte[PAGE_W:1];
              end else if (st == ST_WORD) begin
                ack_q                <= 1'b1;
                addr_q[WORD_W-1:0]   <= rx_byte[WORD_W-1:0];
              end else begin
                ack_q <= !wp;
                if (!wp) addr_q <= addr_q + 1'b1;
              end
            end
          end
        end
        ST_RDATA: begin
          if (!byte_done) begin
            cnt <= cnt + 1'b1;
            if (last_bit) addr_q <= addr_q + 1'b1;
          end
        end
        ST_RDATA_ACK: mack_q <= sda_s;
        default: ;
      endcase
    end else if (scl_fall) begin
      case (st)
        ST_DEV: begin
          if (byte_done) begin
            if (ack_q) begin
              st    <= ST_DEV_ACK;
              drv_q <= 1'b1;
            end else begin
              st    <= ST_IDLE;
              drv_q <= 1'b0;
            end
          end
        end
        ST_DEV_ACK: begin
          cnt <= '0;
          if (sh[0]) begin
            st    <= ST_RDATA;
            tx    <= {rd_data[BYTE_W-2:0], 1'b0};
            drv_q <= ~rd_data[BYTE_W-1];
          end else begin
            st    <= ST_WORD;
            drv_q <= 1'b0;
          end
        end
        ST_WORD: begin
          if (byte_done) begin
            st    <= ST_WORD_ACK;
            drv_q <= ack_q;
          end
        end
        ST_WDATA: begin
          if (byte_done) begin
            st    <= ST_WDATA_ACK;
            drv_q <= ack_q;
          end
        end
        ST_WORD_ACK, ST_WDATA_ACK: begin
          st    <= ST_WDATA;
          cnt   <= '0;
          drv_q <= 1'b0;
        end
        ST_RDATA: begin
          if (byte_done) begin
            st    <= ST_RDATA_ACK;
            drv_q <= 1'b0;
          end else begin
            tx    <= {tx[BYTE_W-2:0], 1'b0};
            drv_q <= ~tx[BYTE_W-1];
          end
        end
        ST_RDATA_ACK: begin
          if (!mack_q) begin
            st    <= ST_RDATA;
            cnt   <= '0;
            tx    <= {rd_data[BYTE_W-2:0], 1'b0};
            drv_q <= ~rd_data[BYTE_W-1];
          end else begin
            st    <= ST_IDLE;
            drv_q <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
  import twi_mem_pkg::*;
#(
  parameter int         ADDR_W      = 11,
  parameter int         PAGE_W      = 3,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_CODE    = 4'b1010
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  input  logic wp,
  output logic sda_drive_low
);

  logic              scl_s;
  logic              sda_s;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic              mem_we;
  logic [BYTE_W-1:0] mem_wdata;
  logic [BYTE_W-1:0] rd_data;
  logic [ADDR_W-1:0] addr;

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  twi_slave_fsm #(
    .ADDR_W  (ADDR_W),
    .PAGE_W  (PAGE_W),
    .DEV_CODE(DEV_CODE)
  ) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .wp           (wp),
    .sda_s        (sda_s),
    .scl_rise     (scl_rise),
    .scl_fall     (scl_fall),
    .start_det    (start_det),
    .stop_det     (stop_det),
    .rd_data      (rd_data),
    .mem_we       (mem_we),
    .mem_wdata    (mem_wdata),
    .addr         (addr),
    .sda_drive_low(sda_drive_low)
  );

  twi_byte_ram #(.AW(ADDR_W), .DW(BYTE_W)) u_ram (
    .clk  (clk),
    .we   (mem_we),
    .waddr(addr),
    .wdata(mem_wdata),
    .raddr(addr),
    .rdata(rd_data)
  );

endmodule

// File: rtl/twi_mem_slave_chk.sv
module twi_mem_slave_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              wp,
  input logic              scl_s,
  input logic              start_det,
  input logic              stop_det,
  input logic              mem_we,
  input logic [ADDR_W-1:0] addr,
  input logic              sda_drive_low
);

  localparam logic [ADDR_W-1:0] TOP = '1;

  // R10: the drive only moves while the synchronized clock is low
  p_drive_scl_low_r10: assert property (@(posedge clk) disable iff (rst)
    (sda_drive_low != $past(sda_drive_low)) |-> !$past(scl_s));

  // R1: a stop leaves the line released
  p_stop_release_r1: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_drive_low);

  // R9: a start leaves the line released
  p_start_release_r9: assert property (@(posedge clk) disable iff (rst)
    start_det |=> !sda_drive_low);

  // R7: protection blocks every array write
  p_wp_block_r7: assert property (@(posedge clk) disable iff (rst)
    wp |-> !mem_we);

  // R5: a write at the top address wraps the latch to zero
  p_addr_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_we && addr == TOP) |=> (addr == '0));

  // R8: array writes happen only on a clock-high sample
  p_write_on_high_r8: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> scl_s);

endmodule

bind twi_mem_slave twi_mem_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .wp           (wp),
  .scl_s        (scl_s),
  .start_det    (start_det),
  .stop_det     (stop_det),
  .mem_we       (mem_we),
  .addr         (addr),
  .sda_drive_low(sda_drive_low)
);

// File: tb/sim_twi_mem_slave.sv
`timescale 1ns/1ps
module sim_twi_mem_slave;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  logic drv;
  wire  sda_bus = sda_m & ~drv;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic       exp_on = 1'b0;
  logic       exp_drv = 1'b0;
  string      exp_req = "";

  logic [7:0]  ref_mem [2048];
  logic [10:0] ref_addr = '0;

  always #4 clk = ~clk;

  twi_mem_slave u0 (
    .clk          (clk),
    .rst          (rst),
    .scl_in       (scl),
    .sda_in       (sda_bus),
    .wp           (wp),
    .sda_drive_low(drv)
  );

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s drive actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (exp_on && !rst && !done) check(drv, exp_drv, exp_req);
  end

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic slot(input logic m_bit, input logic e_drv, input string req);
    scl = 1'b0;
    wclk(4);
    sda_m = m_bit;
    wclk(4);
    scl = 1'b1;
    exp_drv = e_drv;
    exp_req = req;
    exp_on = 1'b1;
    wclk(8);
    exp_on = 1'b0;
  endtask

  task automatic start_cond();
    scl = 1'b0;
    wclk(4);
    sda_m = 1'b1;
    wclk(4);
    scl = 1'b1;
    wclk(4);
    sda_m = 1'b0;
    wclk(4);
  endtask

  task automatic stop_cond(input string req);
    scl = 1'b0;
    wclk(4);
    sda_m = 1'b0;
    wclk(4);
    scl = 1'b1;
    exp_drv = 1'b0;
    exp_req = req;
    exp_on = 1'b1;
    wclk(4);
    sda_m = 1'b1;
    wclk(6);
    exp_on = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input logic e_ack, input string req_ack);
    for (int i = 7; i >= 0; i--) slot(b[i], 1'b0, "R10");
    slot(1'b1, e_ack, req_ack);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) slot(b[i], 1'b0, "R10");
  endtask

  task automatic read_byte(input logic [7:0] e, input logic m_ack, input string req);
    for (int i = 7; i >= 0; i--) slot(1'b1, ~e[i], req);
    slot(~m_ack, 1'b0, "R6");
  endtask

  // write transfer: n data bytes d0, d0+step, ...
  task automatic wr_txn(input logic [2:0] pg, input logic [7:0] word, input int n,
                        input logic [7:0] d0, input logic [7:0] step, input string req);
    logic [7:0] b;
    logic       ack;
    start_cond();
    send_byte({4'b1010, pg, 1'b0}, 1'b1, "R11");
    ref_addr = {pg, word};
    send_byte(word, 1'b1, "R3");
    for (int k = 0; k < n; k++) begin
      b = d0 + 8'(k) * step;
      if (!wp) begin
        ref_mem[ref_addr] = b;
        ref_addr = ref_addr + 11'd1;
        ack = 1'b1;
      end else begin
        ack = 1'b0;
      end
      send_byte(b, ack, req);
    end
    stop_cond("R1");
  endtask

  task automatic rd_txn(input logic [2:0] pg, input int n, input string req);
    start_cond();
    send_byte({4'b1010, pg, 1'b1}, 1'b1, "R2");
    ref_addr = {pg, ref_addr[7:0]};
    for (int k = 0; k < n; k++) begin
      read_byte(ref_mem[ref_addr], k != n - 1, req);
      ref_addr = ref_addr + 11'd1;
    end
    stop_cond("R6");
  endtask

  initial begin
    wclk(5);
    rst = 1'b0;
    wclk(4);
    check(drv, 1'b0, "R1 reset");

    // R3: sequential write of six bytes at page 2, word 0x10
    wr_txn(3'd2, 8'h10, 6, 8'h3C, 8'h11, "R3");
    // R11: address-only write right after a write, then R4 read
    wr_txn(3'd2, 8'h10, 0, 8'h00, 8'h00, "R11");
    rd_txn(3'd2, 4, "R4");
    // R5: a new read continues from the incremented latch
    rd_txn(3'd2, 2, "R5");

    // R4: high address bits come from the read slave byte
    wr_txn(3'd5, 8'h14, 1, 8'hC3, 8'h00, "R3");
    wr_txn(3'd2, 8'h14, 0, 8'h00, 8'h00, "R3");
    rd_txn(3'd5, 1, "R4");

    // R5: wrap from 0x7FF to 0x000 on write and read
    wr_txn(3'd7, 8'hFE, 4, 8'h81, 8'h22, "R5");
    wr_txn(3'd7, 8'hFE, 0, 8'h00, 8'h00, "R5");
    rd_txn(3'd7, 4, "R5");

    // R7: protected writes are not acknowledged, stored or counted
    wp = 1'b1;
    wr_txn(3'd2, 8'h10, 2, 8'hEE, 8'h01, "R7");
    wp = 1'b0;
    rd_txn(3'd2, 1, "R7");

    // R2: wrong device code is ignored, latch untouched
    start_cond();
    send_byte({4'b1011, 3'd2, 1'b0}, 1'b0, "R2");
    send_byte(8'h00, 1'b0, "R2");
    stop_cond("R2");
    rd_txn(3'd2, 1, "R2");

    // R8 + R9: partial data byte abandoned by a repeated start
    start_cond();
    send_byte({4'b1010, 3'd2, 1'b0}, 1'b1, "R11");
    send_byte(8'h12, 1'b1, "R3");
    ref_addr = 11'h212;
    send_bits(8'hFF, 5);
    start_cond();
    send_byte({4'b1010, 3'd2, 1'b1}, 1'b1, "R9");
    read_byte(ref_mem[ref_addr], 1'b0, "R8");
    ref_addr = ref_addr + 11'd1;
    stop_cond("R6");

    // R8: partial data byte abandoned by a stop
    start_cond();
    send_byte({4'b1010, 3'd2, 1'b0}, 1'b1, "R11");
    send_byte(8'h13, 1'b1, "R3");
    ref_addr = 11'h213;
    send_bits(8'h00, 3);
    stop_cond("R8");
    rd_txn(3'd2, 1, "R8");

    wclk(10);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule